// File: doc/BRIEF.md
# Link Bring-Up and Speed Negotiation Sequencer

This block brings a serial link from reset to an operating state in two steps. It first caps the controller's maximum link speed at the lowest generation, enables the training state machine, and polls the physical-layer status word until the link reports up with training finished. Once that happens it raises the speed cap to the second generation and fires a one-cycle request for a directed speed change. It then polls the self-clearing change-pending bit until it drops, and checks the link a second time, because a speed change retrains the link.

If every check in any polling phase times out, the block runs a recovery step through a simple PHY register access port. It reads the receiver override register and writes it back with the data-enable and PLL-enable override bits set. It holds that state for a programmable time, then does a second read-modify-write that clears the two bits. Only after that does it report failure. Poll spacing, retry limits and the override hold time are all set in clock cycles, so a system can use real millisecond timing and a bench can use a short one. Success reports the negotiated speed taken from the link status word.

Top module: `lnk_bringup`

## Requirements
- R1: After reset, train_en, link_ok, link_fail, spd_chg_set and phy_req are 0, link_speed is 0 and speed_cap is 1.
- R2: A start request sets speed_cap to 1 and clears train_en. train_en is raised one cycle later, so training is always enabled with the cap at 1.
- R3: The link counts as ready only when bit 4 (link up) of dbg_stat is 1 and bit 29 (in training) is 0. A link reporting up while still training is not ready.
- R4: The link check is made up to LINK_TRIES times, with LINK_CYC+1 cycles before each check. Failure is declared only after every check has failed, and recovery then begins at once.
- R5: When the first link check succeeds, speed_cap becomes 2 and spd_chg_set pulses high for exactly one cycle, in the same cycle as the new cap.
- R6: After the pulse, bit 17 of spd_ctl_stat is polled up to SPD_TRIES times, SPD_CYC+1 cycles apart. When it reads 0, the link-ready check of R3/R4 is repeated. If it never clears, the block goes to failure.
- R7: On success, link_ok is 1 and link_speed holds bits 19:16 of lnk_stat as sampled when the final check passed. link_speed is 0 whenever link_ok is 0.
- R8: On failure, PHY register 0x1005 is read and written back OR 0x0028 (bits 5 and 3). The block then waits at least HOLD_CYC cycles, reads the register again, and writes it back AND NOT 0x0028. link_fail rises after the second write. Every PHY access uses address 0x1005.
- R9: link_ok and link_fail are never both 1. Each one stays set until the next start request, which clears it in the following cycle. A start request made while a bring-up is running is ignored.
- R10: phy_req, phy_we, phy_addr and phy_wdata (during a write) stay stable from the rise of phy_req until the cycle in which phy_ack is 1. phy_rdata is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new bring-up (accepted when idle or finished) |
| speed_cap | output | 4 | Maximum link speed field driven to the controller |
| train_en | output | 1 | Training state machine enable |
| spd_chg_set | output | 1 | One-cycle pulse setting the directed speed-change bit |
| dbg_stat | input | 32 | PHY debug status word (bit 4 link up, bit 29 in training) |
| spd_ctl_stat | input | 32 | Width/speed control word (bit 17 speed change pending) |
| lnk_stat | input | 32 | Link control/status word (bits 19:16 current speed) |
| phy_req | output | 1 | PHY access request, held until acknowledged |
| phy_we | output | 1 | PHY access is a write |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | PHY access done; read data valid |
| phy_rdata | input | 16 | PHY read data |
| link_ok | output | 1 | Bring-up succeeded (sticky until start) |
| link_fail | output | 1 | Bring-up failed after recovery (sticky until start) |
| link_speed | output | 4 | Negotiated speed on success, 0 otherwise |

## Verification
A partner that supports the second generation checks that the speed-change pulse happens only after the first ready check. It also checks that link_ok waits for the retraining window after the change. A partner limited to the first generation, with noise in the unrelated bits of lnk_stat, shows that link_speed comes from bits 19:16 and not from any other field. Three failing patterns are used: link up but stuck in training, link never up, and speed-change bit never clearing. They show that bit 29 vetoes readiness, that failure waits for the full retry window, and that the speed-change timeout alone also leads to recovery. Two different starting values of the override register show a true read-modify-write: one has bits 5 and 3 already set, and the clear step must restore the other bits. A start pulse in the middle of a run and a long idle period after success check that start is ignored while busy and that link_ok stays set.

// File: rtl/lbs_pkg.sv
`timescale 1ns/1ps
package lbs_pkg;

  localparam int SPD_W = 4;

  localparam logic [SPD_W-1:0] GEN1 = 4'd1;
  localparam logic [SPD_W-1:0] GEN2 = 4'd2;

  // Bit positions decoded from the neighbouring controller's status words
  localparam int LNK_UP_BIT  = 4;
  localparam int IN_TRN_BIT  = 29;
  localparam int SPD_CHG_BIT = 17;
  localparam int CUR_SPD_LSB = 16;

  localparam logic [15:0] RX_OVRD_ADDR = 16'h1005;
  localparam logic [15:0] RX_OVRD_MASK = 16'h0028;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARM, ST_TRAIN1, ST_SPD, ST_TRAIN2,
    ST_REC_SET, ST_REC_HOLD, ST_REC_CLR, ST_OK, ST_FAIL
  } lbs_state_e;

  typedef enum logic [1:0] {RW_IDLE, RW_RD, RW_WR} rmw_state_e;

endpackage

// File: rtl/lbs_poll.sv
`timescale 1ns/1ps
// Interval timer plus retry counter shared by every polling phase.
module lbs_poll #(
  parameter int CW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          begin_i,
  input  logic          retry_i,
  input  logic          stop_i,
  input  logic [CW-1:0] interval_i,
  input  logic [TW-1:0] limit_i,
  output logic          due_o,
  output logic          last_o
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] try_q, try_d;
  logic          act_q, act_d;
  logic [TW:0]   try_next;

  always_comb begin
    cnt_d = cnt_q;
    try_d = try_q;
    act_d = act_q;
    if (begin_i) begin
      cnt_d = interval_i;
      try_d = '0;
      act_d = 1'b1;
    end else if (retry_i) begin
      cnt_d = interval_i;
      try_d = try_q + 1'b1;
    end else if (stop_i) begin
      act_d = 1'b0;
    end else if (act_q && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      try_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      try_q <= try_d;
      act_q <= act_d;
    end
  end

  assign try_next = {1'b0, try_q} + {{TW{1'b0}}, 1'b1};
  assign due_o    = act_q && (cnt_q == '0);
  assign last_o   = try_next >= {1'b0, limit_i};

endmodule

// File: rtl/lbs_phy_rmw.sv
`timescale 1ns/1ps
// Read-modify-write of one PHY register: set or clear a fixed mask.
module lbs_phy_rmw
  import lbs_pkg::*;
#(
  parameter int            AW   = 16,
  parameter int            DW   = 16,
  parameter logic [AW-1:0] ADDR = RX_OVRD_ADDR,
  parameter logic [DW-1:0] MASK = RX_OVRD_MASK
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          set_i,
  output logic          done_o,
  output logic          phy_req,
  output logic          phy_we,
  output logic [AW-1:0] phy_addr,
  output logic [DW-1:0] phy_wdata,
  input  logic          phy_ack,
  input  logic [DW-1:0] phy_rdata
);

  rmw_state_e    st_q, st_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          set_q, set_d;

  always_comb begin
    st_d  = st_q;
    dat_d = dat_q;
    set_d = set_q;
    unique case (st_q)
      RW_IDLE: if (go_i) begin
        st_d  = RW_RD;
        set_d = set_i;
      end
      RW_RD: if (phy_ack) begin
        dat_d = set_q ? (phy_rdata | MASK) : (phy_rdata & ~MASK);
        st_d  = RW_WR;
      end
      RW_WR: if (phy_ack) st_d = RW_IDLE;
      default: st_d = RW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RW_IDLE;
      dat_q <= '0;
      set_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      dat_q <= dat_d;
      set_q <= set_d;
    end
  end

  assign phy_req   = (st_q != RW_IDLE);
  assign phy_we    = (st_q == RW_WR);
  assign phy_addr  = ADDR;
  assign phy_wdata = dat_q;
  assign done_o    = (st_q == RW_WR) && phy_ack;

endmodule

// File: rtl/lnk_bringup.sv
`timescale 1ns/1ps
module lnk_bringup
  import lbs_pkg::*;
#(
  parameter int LINK_TRIES = 200,
  parameter int LINK_CYC   = 100000,
  parameter int SPD_TRIES  = 200,
  parameter int SPD_CYC    = 20000,
  parameter int HOLD_CYC   = 250000,
  parameter int PHY_AW     = 16,
  parameter int PHY_DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [SPD_W-1:0]  speed_cap,
  output logic              train_en,
  output logic              spd_chg_set,
  input  logic [31:0]       dbg_stat,
  input  logic [31:0]       spd_ctl_stat,
  input  logic [31:0]       lnk_stat,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              link_ok,
  output logic              link_fail,
  output logic [SPD_W-1:0]  link_speed
);

  localparam int CYC_A   = (LINK_CYC > SPD_CYC) ? LINK_CYC : SPD_CYC;
  localparam int CYC_MAX = (CYC_A > HOLD_CYC) ? CYC_A : HOLD_CYC;
  localparam int CW      = $clog2(CYC_MAX + 1);
  localparam int TRY_MAX = (LINK_TRIES > SPD_TRIES) ? LINK_TRIES : SPD_TRIES;
  localparam int TW      = $clog2(TRY_MAX + 1);

  localparam logic [CW-1:0] LINK_I = CW'(LINK_CYC);
  localparam logic [CW-1:0] SPD_I  = CW'(SPD_CYC);
  localparam logic [CW-1:0] HOLD_I = CW'(HOLD_CYC);
  localparam logic [TW-1:0] LINK_L = TW'(LINK_TRIES);
  localparam logic [TW-1:0] SPD_L  = TW'(SPD_TRIES);

  lbs_state_e       st_q, st_d;
  logic [SPD_W-1:0] cap_q, cap_d, spd_q, spd_d;
  logic             trn_q, trn_d, pls_q, pls_d;
  logic             ok_q, ok_d, fail_q, fail_d;

  logic          p_begin, p_retry, p_stop, p_due, p_last;
  logic [CW-1:0] p_int;
  logic [TW-1:0] p_lim;
  logic          rmw_go, rmw_set, rmw_done;
  logic          link_ready, spd_busy;
  logic          unused_bits;

  assign link_ready  = dbg_stat[LNK_UP_BIT] & ~dbg_stat[IN_TRN_BIT];
  assign spd_busy    = spd_ctl_stat[SPD_CHG_BIT];
  assign unused_bits = ^{dbg_stat, spd_ctl_stat, lnk_stat};

  lbs_poll #(.CW(CW), .TW(TW)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .begin_i(p_begin), .retry_i(p_retry), .stop_i(p_stop),
    .interval_i(p_int), .limit_i(p_lim),
    .due_o(p_due), .last_o(p_last)
  );

  lbs_phy_rmw #(.AW(PHY_AW), .DW(PHY_DW),
                .ADDR(PHY_AW'(RX_OVRD_ADDR)), .MASK(PHY_DW'(RX_OVRD_MASK))) u_rmw (
    .clk(clk), .rst_n(rst_n),
    .go_i(rmw_go), .set_i(rmw_set), .done_o(rmw_done),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
    .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
  );

  // Interval reloaded on a retry and limit seen by the active phase
  always_comb begin
    p_lim = (st_q == ST_SPD) ? SPD_L : LINK_L;
    unique case (st_q)
      ST_SPD:                 p_int = SPD_I;
      ST_REC_SET, ST_REC_HOLD: p_int = HOLD_I;
      default:                p_int = LINK_I;
    endcase
    if (st_q == ST_TRAIN1 && p_due && link_ready) p_int = SPD_I;
    if (st_q == ST_SPD && p_due && !spd_busy)     p_int = LINK_I;
  end

  always_comb begin
    st_d    = st_q;
    cap_d   = cap_q;
    trn_d   = trn_q;
    pls_d   = 1'b0;
    ok_d    = ok_q;
    fail_d  = fail_q;
    spd_d   = spd_q;
    p_begin = 1'b0;
    p_retry = 1'b0;
    p_stop  = 1'b0;
    rmw_go  = 1'b0;
    rmw_set = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_OK, ST_FAIL: if (start) begin
        st_d   = ST_ARM;
        cap_d  = GEN1;
        trn_d  = 1'b0;
        ok_d   = 1'b0;
        fail_d = 1'b0;
        spd_d  = '0;
      end
      ST_ARM: begin
        trn_d   = 1'b1;
        p_begin = 1'b1;
        st_d    = ST_TRAIN1;
      end
      ST_TRAIN1: if (p_due) begin
        if (link_ready) begin
          cap_d   = GEN2;
          pls_d   = 1'b1;
          p_begin = 1'b1;
          st_d    = ST_SPD;
        end else if (p_last) begin
          p_stop  = 1'b1;
          rmw_go  = 1'b1;
          rmw_set = 1'b1;
          st_d    = ST_REC_SET;
        end else begin
          p_retry = 1'b1;
        end
      end
      ST_SPD: if (p_due) begin
        if (!spd_busy) begin
          p_begin = 1'b1;
          st_d    = ST_TRAIN2;
        end else if (p_last) begin
          p_stop  = 1'b1;
          rmw_go  = 1'b1;
          rmw_set = 1'b1;
          st_d    = ST_REC_SET;
        end else begin
          p_retry = 1'b1;
        end
      end
      ST_TRAIN2: if (p_due) begin
        if (link_ready) begin
          p_stop = 1'b1;
          ok_d   = 1'b1;
          spd_d  = lnk_stat[CUR_SPD_LSB +: SPD_W];
          st_d   = ST_OK;
        end else if (p_last) begin
          p_stop  = 1'b1;
          rmw_go  = 1'b1;
          rmw_set = 1'b1;
          st_d    = ST_REC_SET;
        end else begin
          p_retry = 1'b1;
        end
      end
      ST_REC_SET: if (rmw_done) begin
        p_begin = 1'b1;
        st_d    = ST_REC_HOLD;
      end
      ST_REC_HOLD: if (p_due) begin
        p_stop  = 1'b1;
        rmw_go  = 1'b1;
        rmw_set = 1'b0;
        st_d    = ST_REC_CLR;
      end
      ST_REC_CLR: if (rmw_done) begin
        fail_d = 1'b1;
        st_d   = ST_FAIL;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cap_q  <= GEN1;
      trn_q  <= 1'b0;
      pls_q  <= 1'b0;
      ok_q   <= 1'b0;
      fail_q <= 1'b0;
      spd_q  <= '0;
    end else begin
      st_q   <= st_d;
      cap_q  <= cap_d;
      trn_q  <= trn_d;
      pls_q  <= pls_d;
      ok_q   <= ok_d;
      fail_q <= fail_d;
      spd_q  <= spd_d;
    end
  end

  assign speed_cap   = cap_q;
  assign train_en    = trn_q;
  assign spd_chg_set = pls_q;
  assign link_ok     = ok_q;
  assign link_fail   = fail_q;
  assign link_speed  = spd_q;

endmodule

// File: rtl/lnk_bringup_chk.sv
`timescale 1ns/1ps
module lnk_bringup_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    speed_cap,
  input logic          train_en,
  input logic          spd_chg_set,
  input logic          phy_req,
  input logic          phy_we,
  input logic [AW-1:0] phy_addr,
  input logic [DW-1:0] phy_wdata,
  input logic          phy_ack,
  input logic          link_ok,
  input logic          link_fail,
  input logic [3:0]    link_speed
);

  AST_TRAIN_AT_GEN1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> speed_cap == 4'd1);                                   // R2
  AST_PULSE_AT_GEN2: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_set |-> (speed_cap == 4'd2) && train_en);                        // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    spd_chg_set |=> !spd_chg_set);                                           // R5
  AST_SPEED_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |-> link_speed == 4'd0);                                         // R7
  AST_PHY_ADDR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> phy_addr == AW'(16'h1005));                                   // R8
  AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_ok && link_fail));                                                // R9
  AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    link_ok && !start |=> link_ok);                                          // R9
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    link_fail && !start |=> link_fail);                                      // R9
  AST_PHY_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req && $stable(phy_we) && $stable(phy_addr)); // R10
  AST_PHY_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && phy_we && !phy_ack |=> $stable(phy_wdata));                   // R10

endmodule

bind lnk_bringup lnk_bringup_chk #(.AW(PHY_AW), .DW(PHY_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .speed_cap(speed_cap),
  .train_en(train_en), .spd_chg_set(spd_chg_set), .phy_req(phy_req),
  .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
  .phy_ack(phy_ack), .link_ok(link_ok), .link_fail(link_fail),
  .link_speed(link_speed)
);

// File: tb/lnk_bringup_test.sv
`timescale 1ns/1ps
module lnk_bringup_test;

  localparam int LT = 200, LC = 20, ST = 50, SC = 10, HC = 40;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [3:0]  speed_cap, link_speed;
  logic        train_en, spd_chg_set, link_ok, link_fail;
  logic [31:0] dbg_stat, spd_ctl_stat, lnk_stat;
  logic        phy_req, phy_we, phy_ack;
  logic [15:0] phy_addr, phy_wdata, phy_rdata;

  always #2.5 clk = ~clk;

  lnk_bringup #(.LINK_TRIES(LT), .LINK_CYC(LC), .SPD_TRIES(ST), .SPD_CYC(SC),
                .HOLD_CYC(HC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .speed_cap(speed_cap),
    .train_en(train_en), .spd_chg_set(spd_chg_set), .dbg_stat(dbg_stat),
    .spd_ctl_stat(spd_ctl_stat), .lnk_stat(lnk_stat), .phy_req(phy_req),
    .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata), .link_ok(link_ok),
    .link_fail(link_fail), .link_speed(link_speed)
  );

  int checks = 0, errors = 0;

  // partner model configuration
  int up_at, trn_at, spd_dly, retrain, partner;
  bit never_up, stuck_trn, spd_never;
  // partner model state and event log
  int cyc = 0, tcnt = 0, pcnt = 0, rt = 0, acnt = 0;
  bit pend = 0, spd_done = 0, trn_prev = 0, ok_prev = 0, req_prev = 0;
  int trains, pulses, ok_rises, cap_at_rise, spd_done_cyc, ok_cyc, first_req_cyc;
  int wr_n;
  logic [15:0] phyreg;
  logic [15:0] wr_val [4];
  int          wr_cyc [4];
  int          start_cyc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    // controller model
    if (!train_en) begin
      tcnt = 0; pend = 0; spd_done = 0; rt = 0;
    end else begin
      tcnt++;
      if (spd_chg_set) begin
        pend = 1; pcnt = 0;
      end else if (pend) begin
        pcnt++;
        if (!spd_never && pcnt >= spd_dly) begin
          pend = 0; spd_done = 1; rt = retrain; spd_done_cyc = cyc;
        end
      end else if (rt > 0) rt--;
    end
    dbg_stat = 32'h0000_000A;
    dbg_stat[4]  = !never_up && (tcnt >= up_at) && train_en;
    dbg_stat[29] = (tcnt < trn_at) || stuck_trn || (rt > 0);
    spd_ctl_stat = 32'h0004_0003;
    spd_ctl_stat[17] = pend;
    lnk_stat = 32'h0070_000F;
    lnk_stat[19:16] = (spd_done && partner >= 2 && speed_cap >= 4'd2) ? 4'd2 : 4'd1;
    // PHY model
    if (phy_ack) begin
      phy_ack = 0; acnt = 0;
    end else if (phy_req) begin
      acnt++;
      if (acnt == 2) begin
        phy_ack = 1; phy_rdata = phyreg;
        if (phy_we) begin
          phyreg = phy_wdata;
          if (wr_n < 4) begin wr_val[wr_n] = phy_wdata; wr_cyc[wr_n] = cyc; end
          wr_n++;
        end
      end
    end
    // event monitor
    if (train_en && !trn_prev) begin trains++; cap_at_rise = speed_cap; end
    if (spd_chg_set) pulses++;
    if (link_ok && !ok_prev) begin ok_rises++; ok_cyc = cyc; end
    if (phy_req && !req_prev && first_req_cyc < 0) first_req_cyc = cyc;
    trn_prev = train_en; ok_prev = link_ok; req_prev = phy_req;
  end

  task automatic setup(input int u, input int t, input bit nu, input bit st_,
                       input int sd, input bit sn, input int r, input int p,
                       input logic [15:0] preg);
    up_at = u; trn_at = t; never_up = nu; stuck_trn = st_;
    spd_dly = sd; spd_never = sn; retrain = r; partner = p; phyreg = preg;
    trains = 0; pulses = 0; ok_rises = 0; cap_at_rise = -1; wr_n = 0;
    spd_done_cyc = 0; ok_cyc = 0; first_req_cyc = -1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; start_cyc = cyc;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!(link_ok || link_fail) && n < 20000) begin @(negedge clk); n++; end
    if (n >= 20000) begin checks++; errors++; $display("FAIL %s actual=timeout expected=done", req); end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 train_en", train_en, 0);
    chk("R1 link_ok", link_ok, 0);
    chk("R1 link_fail", link_fail, 0);
    chk("R1 phy_req", phy_req, 0);
    chk("R1 spd_chg_set", spd_chg_set, 0);
    chk("R1 link_speed", link_speed, 0);
    chk("R1 speed_cap", speed_cap, 1);
  endtask

  task automatic t_gen2();
    setup(10, 25, 0, 0, 6, 0, 30, 2, 16'h00C4);
    pulse_start(); wait_done("R7 gen2");
    chk("R7 link_ok", link_ok, 1);
    chk("R9 link_fail low", link_fail, 0);
    chk("R7 speed gen2", link_speed, 2);
    chk("R5 cap raised", speed_cap, 2);
    chk("R5 one pulse", pulses, 1);
    chk("R2 cap at train rise", cap_at_rise, 1);
    chk("R2 one train rise", trains, 1);
    chk("R6 ok after retrain", (ok_cyc - spd_done_cyc) >= retrain, 1);
    chk("R8 no phy writes", wr_n, 0);
    repeat (300) @(negedge clk);
    chk("R9 ok held", link_ok, 1);
    chk("R9 speed held", link_speed, 2);
  endtask

  task automatic t_gen1_partner();
    setup(5, 8, 0, 0, 4, 0, 0, 1, 16'h00C4);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R9 start clears ok", link_ok, 0);
    chk("R2 train off after start", train_en, 0);
    wait_done("R7 gen1");
    chk("R7 speed gen1", link_speed, 1);
    chk("R7 ok gen1", link_ok, 1);
  endtask

  task automatic t_stuck_training();
    setup(5, 0, 0, 1, 4, 0, 0, 2, 16'h00C4);
    pulse_start(); wait_done("R3 stuck");
    chk("R3 fail when in training", link_fail, 1);
    chk("R3 never ok", ok_rises, 0);
    chk("R3 no speed change", pulses, 0);
    chk("R4 not before window", (first_req_cyc - start_cyc) >= LT * LC, 1);
    chk("R4 right after window", (first_req_cyc - start_cyc) <= LT * (LC + 1) + 10, 1);
    chk("R8 two writes", wr_n, 2);
    chk("R8 set write", wr_val[0], 16'h00EC);
    chk("R8 clear write", wr_val[1], 16'h00C4);
    chk("R8 hold time", (wr_cyc[1] - wr_cyc[0]) >= HC, 1);
    chk("R7 speed zero on fail", link_speed, 0);
  endtask

  task automatic t_never_up();
    setup(0, 0, 1, 0, 4, 0, 0, 2, 16'h0F2C);
    pulse_start(); wait_done("R4 down");
    chk("R4 fail link down", link_fail, 1);
    chk("R9 ok low on fail", link_ok, 0);
    chk("R8 set keeps bits", wr_val[0], 16'h0F2C);
    chk("R8 clear keeps others", wr_val[1], 16'h0F04);
    repeat (200) @(negedge clk);
    chk("R9 fail held", link_fail, 1);
  endtask

  task automatic t_spd_stuck();
    setup(6, 9, 0, 0, 0, 1, 0, 2, 16'h00C4);
    pulse_start(); wait_done("R6 stuck");
    chk("R6 fail on stuck change", link_fail, 1);
    chk("R6 one pulse", pulses, 1);
    chk("R8 recovery writes", wr_n, 2);
  endtask

  task automatic t_busy_start();
    setup(10, 15, 0, 0, 5, 0, 10, 2, 16'h00C4);
    pulse_start();
    repeat (5) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done("R9 busy");
    chk("R9 busy start ignored", trains, 1);
    chk("R9 result after busy start", link_ok, 1);
  endtask

  initial begin
    rst_n = 0; start = 0; phy_ack = 0; phy_rdata = 0;
    setup(10, 25, 0, 0, 6, 0, 30, 2, 16'h00C4);
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gen2();
    t_gen1_partner();
    t_stuck_training();
    t_never_up();
    t_spd_stuck();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule